// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each received Ethernet frame, whether the frame should be kept. The decision is based on the frame's 48-bit destination address, which arrives as six bytes in wire order, one byte per valid cycle. The address is checked in a fixed order. A unicast address is checked first against one programmed station address and then against a 64-bin individual hash table. A multicast address is checked first against broadcast and then against a 64-bin group hash table. If none of these checks matches, promiscuous mode and an optional external CAM decide the outcome.

The hash bin comes from a CRC-32 that runs over the address one byte per clock. A command port uses the same CRC datapath. It hashes a 48-bit target address and sets the resulting bin in either the group table or the individual table. A clear command empties both tables. The receive path always has priority on the CRC datapath. A pending set waits while an address is being received, and a set that was partly hashed starts over after the address is complete.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: A decision (`dec_vld` high for one cycle) appears in the cycle after the sixth address byte. An address starts with a byte that has `rx_first` high, and a byte with `rx_first` high restarts a partly received address. A valid byte with `rx_first` low that arrives when no address is open is ignored.
- R2: A unicast address (bit 0 of the first wire byte is 0) that equals `sta_addr` is accepted with reason 1 (station). This check wins over a set bin in the individual table. The first wire byte is `sta_addr[47:40]`.
- R3: A unicast address that differs from `sta_addr` is accepted with reason 2 (individual hash) when its bin is set in the individual table.
- R4: The bin is computed as follows. The CRC register starts at all ones. Each data bit, taken least significant bit first within each byte and bytes in wire order, is XORed with register bit 31. If the result is 1, the register is shifted left and XORed with 0x04C11DB7; otherwise it is only shifted left. There is no final inversion. The bin is register bits [5:0], and bin n is table bit n (bins 32 to 63 form the high word).
- R5: The all-ones address is accepted with reason 3 (broadcast) when `bcast_en` is 1. When `bcast_en` is 0, it has no on-chip match and the group table is not consulted for it.
- R6: A multicast address that is not broadcast is accepted with reason 4 (group hash) when its bin is set in the group table.
- R7: When no on-chip check matches, `promisc_en` is 1 and `cam_en` is 0, the frame is accepted with reason 5 (promiscuous).
- R8: When no on-chip check matches and both `promisc_en` and `cam_en` are 1, `dec_accept` is 0, the reason is 6 (CAM pending), and `cam_req` pulses together with `dec_vld`. An on-chip match never raises `cam_req`.
- R9: When no on-chip check matches and `promisc_en` is 0, the frame is rejected with reason 0 and no CAM request, whatever `cam_en` is.
- R10: A one-cycle `cmd_set` captures `cmd_addr` and `cmd_group` (1 selects the group table, 0 the individual table). Hashing then takes six cycles in which no address is being received. The chosen bin is set at the end of the sixth such cycle.
- R11: While an address is being received (from its first byte until its sixth), a pending set does not hash. If the set was interrupted after hashing had begun, it restarts from the first byte of its target address.
- R12: A `cmd_set` that arrives while an earlier set is still pending is ignored.
- R13: `cmd_clear` zeroes both tables in one cycle. It also cancels a pending set, and it wins over a `cmd_set` in the same cycle.
- R14: After reset, both tables are empty and `dec_vld`, `dec_accept`, `dec_reason` and `cam_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_vld | input | 1 | Address byte valid |
| rx_first | input | 1 | Marks the first byte of an address |
| rx_byte | input | 8 | Address byte, wire order |
| sta_addr | input | 48 | Station address, [47:40] is the first wire byte |
| bcast_en | input | 1 | Accept the all-ones address |
| promisc_en | input | 1 | Accept frames with no on-chip match |
| cam_en | input | 1 | Send unmatched frames to the external CAM (with promiscuous mode) |
| cmd_set | input | 1 | One-cycle request to hash `cmd_addr` into a table |
| cmd_group | input | 1 | Table select for the set: 1 group, 0 individual |
| cmd_addr | input | 48 | Target address of the set, [47:40] is the first wire byte |
| cmd_clear | input | 1 | Zero both tables |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 reject, 1 station, 2 individual hash, 3 broadcast, 4 group hash, 5 promiscuous, 6 CAM pending |
| cam_req | output | 1 | External CAM lookup request |

## Verification
The bound checker follows the byte stream by itself and checks on every cycle the properties that need no CRC. It checks that the decision strobe lands one cycle after the sixth byte, that a station match always takes priority, and how broadcast is handled under both settings of its enable. It also checks that promiscuous mode never rejects and that reject, CAM request and accept stay consistent with each other. Some behaviour only the bench's reference model and scenarios can show: the exact hash bin, the timing of a set against interrupting receptions, a set dropped because another is pending, and the precedence of clear over set.

// File: rtl/afl_pkg.sv
package afl_pkg;

    localparam int                CRC_W    = 32;
    localparam logic [CRC_W-1:0]  CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0]  CRC_SEED = '1;

    // Decision reason codes
    typedef enum logic [2:0] {
        RSN_REJECT  = 3'd0,
        RSN_STATION = 3'd1,
        RSN_IHASH   = 3'd2,
        RSN_BCAST   = 3'd3,
        RSN_GHASH   = 3'd4,
        RSN_PROMISC = 3'd5,
        RSN_CAM     = 3'd6
    } reason_e;

    // One byte of the CRC: data bits enter LSB first, register shifts left.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] crc_in,
                                                  input logic [7:0]       data);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/afl_crc_unit.sv
// Shared CRC-32 datapath, one byte per enabled cycle.
module afl_crc_unit
    import afl_pkg::*;
#(
    parameter int BIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             seed_sel,
    input  logic [7:0]       data_in,
    output logic [BIN_W-1:0] bin_next
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_st_t;

    crc_st_t          s_d, s_q;
    logic [CRC_W-1:0] crc_nxt;

    always_comb begin
        s_d     = s_q;
        crc_nxt = crc_byte(seed_sel ? CRC_SEED : s_q.crc, data_in);
        if (step_en) s_d.crc = crc_nxt;
    end

    assign bin_next = crc_nxt[BIN_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{crc: CRC_SEED};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/afl_hash_tables.sv
// Individual (index 0) and group (index 1) bin tables.
module afl_hash_tables #(
    parameter int HASH_BINS = 64,
    parameter int BIN_W     = $clog2(HASH_BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             wr_grp,
    input  logic [BIN_W-1:0] wr_bin,
    input  logic [BIN_W-1:0] rd_bin,
    output logic             ind_hit,
    output logic             grp_hit
);

    localparam int N_TBL = 2;

    logic [N_TBL-1:0] hit;

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        logic [HASH_BINS-1:0] bits_d, bits_q;

        always_comb begin
            bits_d = bits_q;
            if (clr)
                bits_d = '0;
            else if (wr_en && (wr_grp == 1'(t)))
                bits_d[wr_bin] = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bits_q <= '0;
            else        bits_q <= bits_d;
        end

        assign hit[t] = bits_q[rd_bin];
    end

    assign ind_hit = hit[0];
    assign grp_hit = hit[1];

endmodule

// File: rtl/afl_match_logic.sv
// Ordered accept/reject decision for a complete destination address.
module afl_match_logic
    import afl_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] sta_addr,
    input  logic              ind_hit,
    input  logic              grp_hit,
    input  logic              bcast_en,
    input  logic              promisc_en,
    input  logic              cam_en,
    output reason_e           reason,
    output logic              accept,
    output logic              cam_req
);

    logic    is_grp, is_bc;
    reason_e onchip;

    always_comb begin
        is_grp = addr[ADDR_W-8];
        is_bc  = &addr;
        onchip = RSN_REJECT;
        if (!is_grp) begin
            if (addr == sta_addr)   onchip = RSN_STATION;
            else if (ind_hit)       onchip = RSN_IHASH;
        end else if (is_bc) begin
            if (bcast_en)           onchip = RSN_BCAST;
        end else if (grp_hit) begin
            onchip = RSN_GHASH;
        end

        reason = onchip;
        if ((onchip == RSN_REJECT) && promisc_en)
            reason = cam_en ? RSN_CAM : RSN_PROMISC;

        accept  = (reason != RSN_REJECT) && (reason != RSN_CAM);
        cam_req = (reason == RSN_CAM);
    end

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
    import afl_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BINS  = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_byte_vld,
    input  logic                    rx_first,
    input  logic [7:0]              rx_byte,
    input  logic [8*ADDR_BYTES-1:0] sta_addr,
    input  logic                    bcast_en,
    input  logic                    promisc_en,
    input  logic                    cam_en,
    input  logic                    cmd_set,
    input  logic                    cmd_group,
    input  logic [8*ADDR_BYTES-1:0] cmd_addr,
    input  logic                    cmd_clear,
    output logic                    dec_vld,
    output logic                    dec_accept,
    output logic [2:0]              dec_reason,
    output logic                    cam_req
);

    localparam int              ADDR_W   = 8 * ADDR_BYTES;
    localparam int              BIN_W    = $clog2(HASH_BINS);
    localparam int              CNT_W    = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  rx_cnt;
        logic [ADDR_W-1:0] rx_addr;
        logic              cmd_pend;
        logic              cmd_grp;
        logic [ADDR_W-1:0] cmd_addr;
        logic [CNT_W-1:0]  cmd_cnt;
        logic              dec_vld;
        logic              dec_acc;
        logic [2:0]        dec_rsn;
        logic              cam_req;
    } flt_st_t;

    flt_st_t s_d, s_q;

    logic              rx_step, rx_last, rx_busy;
    logic              cmd_go, cmd_done;
    logic [7:0]        cmd_byte, crc_in;
    logic              crc_seed;
    logic [BIN_W-1:0]  bin;
    logic [ADDR_W-1:0] rx_full;
    logic              ind_hit, grp_hit;
    reason_e           m_rsn;
    logic              m_acc, m_cam;

    // ---------------- control: stream tracking and CRC ownership ----------------
    always_comb begin
        rx_step  = rx_byte_vld && (rx_first || (s_q.rx_cnt != '0));
        rx_last  = rx_step && !rx_first && (s_q.rx_cnt == LAST_IDX);
        rx_busy  = rx_step || (s_q.rx_cnt != '0);
        rx_full  = {s_q.rx_addr[ADDR_W-9:0], rx_byte};

        cmd_go   = s_q.cmd_pend && !rx_busy && !cmd_clear;
        cmd_done = cmd_go && (s_q.cmd_cnt == LAST_IDX);

        cmd_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (s_q.cmd_cnt == CNT_W'(i))
                cmd_byte = s_q.cmd_addr[ADDR_W-1-8*i -: 8];
        end

        crc_seed = rx_step ? rx_first : (s_q.cmd_cnt == '0);
        crc_in   = rx_step ? rx_byte  : cmd_byte;
    end

    afl_crc_unit #(.BIN_W(BIN_W)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (rx_step || cmd_go),
        .seed_sel (crc_seed),
        .data_in  (crc_in),
        .bin_next (bin)
    );

    afl_hash_tables #(.HASH_BINS(HASH_BINS), .BIN_W(BIN_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_clear),
        .wr_en   (cmd_done),
        .wr_grp  (s_q.cmd_grp),
        .wr_bin  (bin),
        .rd_bin  (bin),
        .ind_hit (ind_hit),
        .grp_hit (grp_hit)
    );

    afl_match_logic #(.ADDR_W(ADDR_W)) u_match (
        .addr       (rx_full),
        .sta_addr   (sta_addr),
        .ind_hit    (ind_hit),
        .grp_hit    (grp_hit),
        .bcast_en   (bcast_en),
        .promisc_en (promisc_en),
        .cam_en     (cam_en),
        .reason     (m_rsn),
        .accept     (m_acc),
        .cam_req    (m_cam)
    );

    // ---------------- next state ----------------
    always_comb begin
        s_d         = s_q;
        s_d.dec_vld = 1'b0;
        s_d.cam_req = 1'b0;

        if (rx_step) begin
            s_d.rx_addr = rx_full;
            if (rx_last)       s_d.rx_cnt = '0;
            else if (rx_first) s_d.rx_cnt = CNT_W'(1);
            else               s_d.rx_cnt = s_q.rx_cnt + 1'b1;
        end

        if (rx_last) begin
            s_d.dec_vld = 1'b1;
            s_d.dec_acc = m_acc;
            s_d.dec_rsn = m_rsn;
            s_d.cam_req = m_cam;
        end

        if (cmd_clear) begin
            s_d.cmd_pend = 1'b0;
            s_d.cmd_cnt  = '0;
        end else if (s_q.cmd_pend) begin
            if (cmd_go) begin
                if (cmd_done) begin
                    s_d.cmd_pend = 1'b0;
                    s_d.cmd_cnt  = '0;
                end else begin
                    s_d.cmd_cnt = s_q.cmd_cnt + 1'b1;
                end
            end else if (rx_step) begin
                s_d.cmd_cnt = '0;
            end
        end else if (cmd_set) begin
            s_d.cmd_pend = 1'b1;
            s_d.cmd_grp  = cmd_group;
            s_d.cmd_addr = cmd_addr;
            s_d.cmd_cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dec_vld    = s_q.dec_vld;
    assign dec_accept = s_q.dec_acc;
    assign dec_reason = s_q.dec_rsn;
    assign cam_req    = s_q.cam_req;

endmodule

// File: rtl/afl_checker.sv
module afl_checker
    import afl_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rx_byte_vld,
    input logic                    rx_first,
    input logic [7:0]              rx_byte,
    input logic [8*ADDR_BYTES-1:0] sta_addr,
    input logic                    bcast_en,
    input logic                    promisc_en,
    input logic                    cam_en,
    input logic                    dec_vld,
    input logic                    dec_accept,
    input logic [2:0]              dec_reason,
    input logic                    cam_req
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int CNT_W  = $clog2(ADDR_BYTES);

    logic [CNT_W-1:0]  n_q;
    logic [ADDR_W-1:0] a_q, a_full;
    logic              take, fin;
    logic              last_q, sta_q, bc_q, bcen_q, prom_q, cam_q;

    always_comb begin
        take   = rx_byte_vld && (rx_first || (n_q != '0));
        fin    = take && !rx_first && (n_q == CNT_W'(ADDR_BYTES - 1));
        a_full = {a_q[ADDR_W-9:0], rx_byte};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0; a_q <= '0; last_q <= 1'b0;
            sta_q <= 1'b0; bc_q <= 1'b0; bcen_q <= 1'b0; prom_q <= 1'b0; cam_q <= 1'b0;
        end else begin
            last_q <= fin;
            if (take) begin
                a_q <= a_full;
                if (fin)           n_q <= '0;
                else if (rx_first) n_q <= CNT_W'(1);
                else               n_q <= n_q + 1'b1;
            end
            if (fin) begin
                sta_q  <= (a_full == sta_addr) && !a_full[ADDR_W-8];
                bc_q   <= &a_full;
                bcen_q <= bcast_en;
                prom_q <= promisc_en;
                cam_q  <= cam_en;
            end
        end
    end

    AST_DEC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld == last_q); // R1

    AST_STATION_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && sta_q) |-> (dec_reason == RSN_STATION) && dec_accept); // R2

    AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && bc_q && bcen_q) |-> (dec_reason == RSN_BCAST)); // R5

    AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && bc_q && !bcen_q && !prom_q) |-> !dec_accept); // R5

    AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && prom_q && !cam_q) |-> dec_accept); // R7

    AST_CAM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cam_req |-> dec_vld && !dec_accept && (dec_reason == RSN_CAM)); // R8

    AST_CLOSED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !prom_q && !dec_accept) |-> (dec_reason == RSN_REJECT) && !cam_req); // R9

endmodule

bind eth_rx_addr_filter afl_checker #(.ADDR_BYTES(ADDR_BYTES)) u_afl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_byte_vld (rx_byte_vld),
    .rx_first    (rx_first),
    .rx_byte     (rx_byte),
    .sta_addr    (sta_addr),
    .bcast_en    (bcast_en),
    .promisc_en  (promisc_en),
    .cam_en      (cam_en),
    .dec_vld     (dec_vld),
    .dec_accept  (dec_accept),
    .dec_reason  (dec_reason),
    .cam_req     (cam_req)
);

// File: tb/eth_rx_addr_filter_bench.sv
module eth_rx_addr_filter_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_byte_vld = 1'b0;
    logic        rx_first = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [47:0] sta_addr = 48'h02_11_22_33_44_55;
    logic        bcast_en = 1'b0;
    logic        promisc_en = 1'b0;
    logic        cam_en = 1'b0;
    logic        cmd_set = 1'b0;
    logic        cmd_group = 1'b0;
    logic [47:0] cmd_addr = '0;
    logic        cmd_clear = 1'b0;
    logic        dec_vld, dec_accept, cam_req;
    logic [2:0]  dec_reason;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_rx_addr_filter u_eth_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_first(rx_first),
        .rx_byte(rx_byte), .sta_addr(sta_addr), .bcast_en(bcast_en),
        .promisc_en(promisc_en), .cam_en(cam_en), .cmd_set(cmd_set),
        .cmd_group(cmd_group), .cmd_addr(cmd_addr), .cmd_clear(cmd_clear),
        .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_reason(dec_reason),
        .cam_req(cam_req)
    );

    // ---------------- reference model state ----------------
    int          n_chk = 0;
    int          n_fail = 0;
    string       cur_tag = "R14";
    int          m_rx_cnt = 0;
    logic [47:0] m_rx_addr = '0;
    logic        m_pend = 1'b0;
    logic        m_grp = 1'b0;
    logic [47:0] m_caddr = '0;
    int          m_steps = 0;
    logic [63:0] m_itab = '0;
    logic [63:0] m_gtab = '0;
    logic        e_vld = 1'b0;
    logic        e_acc = 1'b0;
    logic        e_cam = 1'b0;
    int          e_rsn = 0;
    int          obs_rsn = -1;

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    function automatic int ref_bin(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  d;
        logic        top;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            d = a[47-8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                top = c[31];
                c = c << 1;
                if (top ^ d[i]) c = c ^ 32'h04C1_1DB7;
            end
        end
        return int'(c[5:0]);
    endfunction

    function automatic int ref_decide(input logic [47:0] a);
        int b;
        b = ref_bin(a);
        if (!a[40]) begin
            if (a == sta_addr) return 1;
            if (m_itab[b])     return 2;
        end else if (a == BCAST) begin
            if (bcast_en)      return 3;
        end else if (m_gtab[b]) begin
            return 4;
        end
        if (promisc_en) return cam_en ? 6 : 5;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
        end
    endtask

    // Advance the model with the inputs now applied, one clock.
    task automatic model_eval();
        bit rs, rl, rb;
        logic [47:0] full;
        int b;
        rs = rx_byte_vld && (rx_first || m_rx_cnt != 0);
        rl = rs && !rx_first && m_rx_cnt == 5;
        rb = rs || m_rx_cnt != 0;
        e_vld = 1'b0;
        e_cam = 1'b0;
        if (rl) begin
            full  = {m_rx_addr[39:0], rx_byte};
            e_rsn = ref_decide(full);
            e_vld = 1'b1;
            e_acc = (e_rsn >= 1 && e_rsn <= 5);
            e_cam = (e_rsn == 6);
        end
        if (rs) begin
            m_rx_addr = {m_rx_addr[39:0], rx_byte};
            m_rx_cnt  = rl ? 0 : (rx_first ? 1 : m_rx_cnt + 1);
        end
        if (cmd_clear) begin
            m_itab = '0; m_gtab = '0; m_pend = 1'b0; m_steps = 0;
        end else if (m_pend) begin
            if (!rb) begin
                m_steps++;
                if (m_steps == 6) begin
                    b = ref_bin(m_caddr);
                    if (m_grp) m_gtab[b] = 1'b1;
                    else       m_itab[b] = 1'b1;
                    m_pend = 1'b0;
                    m_steps = 0;
                end
            end else if (rs) begin
                m_steps = 0;
            end
        end else if (cmd_set) begin
            m_pend = 1'b1; m_grp = cmd_group; m_caddr = cmd_addr; m_steps = 0;
        end
    endtask

    task automatic compare();
        chk(dec_vld === e_vld, "dec_vld", int'(dec_vld), int'(e_vld));
        chk(cam_req === e_cam, "cam_req", int'(cam_req), int'(e_cam));
        if (e_vld) begin
            chk(dec_accept === e_acc, "dec_accept", int'(dec_accept), int'(e_acc));
            chk(int'(dec_reason) == e_rsn, "dec_reason", int'(dec_reason), e_rsn);
        end
        if (dec_vld === 1'b1) obs_rsn = int'(dec_reason);
    endtask

    task automatic tick();
        model_eval();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        rx_byte_vld = 1'b0; rx_first = 1'b0; cmd_set = 1'b0; cmd_clear = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    // Send a full address; optional gap after byte 2, with an optional set in its first cycle.
    task automatic send(input logic [47:0] a, input int gap, input bit with_cmd,
                        input logic [47:0] ca, input bit cg);
        obs_rsn = -1;
        for (int k = 0; k < 6; k++) begin
            rx_byte_vld = 1'b1;
            rx_first    = (k == 0);
            rx_byte     = a[47-8*k -: 8];
            tick();
            if (k == 2 && gap > 0) begin
                rx_byte_vld = 1'b0;
                for (int g = 0; g < gap; g++) begin
                    cmd_set = with_cmd && (g == 0);
                    cmd_group = cg; cmd_addr = ca;
                    tick();
                end
                cmd_set = 1'b0;
            end
        end
        rx_byte_vld = 1'b0; rx_first = 1'b0;
    endtask

    task automatic send_a(input logic [47:0] a);
        send(a, 0, 1'b0, '0, 1'b0);
    endtask

    task automatic do_set(input logic [47:0] a, input bit grp);
        cmd_set = 1'b1; cmd_group = grp; cmd_addr = a;
        tick();
        cmd_set = 1'b0;
    endtask

    task automatic do_clear();
        cmd_clear = 1'b1;
        tick();
        cmd_clear = 1'b0;
    endtask

    task automatic expect_rsn(input string tag, input int exp);
        cur_tag = tag;
        chk(obs_rsn == exp, "observed reason", obs_rsn, exp);
    endtask

    logic [47:0] pool [8];

    initial begin
        logic [47:0] ua, ub, ga;
        pool[0] = 48'h02_11_22_33_44_55; pool[1] = 48'h00_A0_C9_14_C8_29;
        pool[2] = 48'h00_1B_21_3A_9F_02; pool[3] = 48'hFFFF_FFFF_FFFF;
        pool[4] = 48'h01_00_5E_00_00_FB; pool[5] = 48'h33_33_00_00_00_01;
        pool[6] = 48'h01_80_C2_00_00_0E; pool[7] = 48'h0A_0B_0C_0D_0E_0F;
        ua = pool[1]; ub = pool[2]; ga = pool[4];

        // R14: reset state
        cur_tag = "R14";
        repeat (3) begin
            @(negedge clk);
            chk(dec_vld === 1'b0 && dec_accept === 1'b0 && cam_req === 1'b0 && dec_reason === 3'd0,
                "outputs in reset", int'({dec_vld, dec_accept, cam_req, dec_reason}), 0);
        end
        rst_n = 1'b1;
        idle(2);

        // R9: empty tables, closed mode
        cur_tag = "R9"; send_a(ua); expect_rsn("R9", 0);
        cam_en = 1'b1; send_a(ua); expect_rsn("R9", 0); cam_en = 1'b0;

        // R2: station match
        cur_tag = "R2"; send_a(sta_addr); expect_rsn("R2", 1);

        // R3/R10: individual set then hit
        cur_tag = "R10"; do_set(ua, 1'b0); idle(7);
        cur_tag = "R3"; send_a(ua); expect_rsn("R3", 2);
        if (ref_bin(ub) != ref_bin(ua)) begin send_a(ub); expect_rsn("R3", 0); end

        // R2 priority over an individual hit
        cur_tag = "R2"; do_set(sta_addr, 1'b0); idle(7); send_a(sta_addr); expect_rsn("R2", 1);

        // R5: broadcast enabled / disabled with its bin in the group table
        cur_tag = "R5"; bcast_en = 1'b1; send_a(BCAST); expect_rsn("R5", 3);
        do_set(BCAST, 1'b1); idle(7); bcast_en = 1'b0; send_a(BCAST); expect_rsn("R5", 0);

        // R6: group hash
        cur_tag = "R6"; do_set(ga, 1'b1); idle(7); send_a(ga); expect_rsn("R6", 4);

        // R7/R8: promiscuous, CAM
        cur_tag = "R7"; do_clear(); promisc_en = 1'b1; send_a(ub); expect_rsn("R7", 5);
        cur_tag = "R8"; cam_en = 1'b1; send_a(ub); expect_rsn("R8", 6);
        send_a(sta_addr); expect_rsn("R8", 1);
        promisc_en = 1'b0; cam_en = 1'b0;

        // R11: set issued in a mid-address gap, then a set interrupted by a reception
        cur_tag = "R11"; do_clear();
        send(pool[7], 4, 1'b1, ua, 1'b0); idle(8); send_a(ua); expect_rsn("R11", 2);
        do_clear(); do_set(ub, 1'b0); idle(2); send_a(pool[7]); idle(8);
        send_a(ub); expect_rsn("R11", 2);

        // R12: second set while the first is pending
        cur_tag = "R12"; do_clear(); do_set(ua, 1'b0); do_set(ub, 1'b0); idle(10);
        send_a(ub); if (ref_bin(ub) != ref_bin(ua)) expect_rsn("R12", 0);

        // R13: clear empties, and beats a simultaneous set
        cur_tag = "R13"; do_clear(); do_set(ua, 1'b0); idle(7); do_clear(); send_a(ua); expect_rsn("R13", 0);
        cmd_clear = 1'b1; cmd_set = 1'b1; cmd_addr = ua; cmd_group = 1'b0; tick();
        cmd_clear = 1'b0; cmd_set = 1'b0; idle(8); send_a(ua); expect_rsn("R13", 0);

        // R1: stray byte and restart mid-address
        cur_tag = "R1"; rx_byte_vld = 1'b1; rx_first = 1'b0; rx_byte = 8'h5A; tick(); idle(1);
        rx_byte_vld = 1'b1; rx_first = 1'b1; rx_byte = 8'h02; tick();
        rx_first = 1'b0; rx_byte = 8'h11; tick(); idle(1);
        send_a(sta_addr); expect_rsn("R1", 1);

        // R4: random traffic against the CRC reference
        cur_tag = "R4";
        for (int it = 0; it < 600; it++) begin
            int act;
            act = int'($urandom_range(0, 9));
            bcast_en = 1'($urandom); promisc_en = 1'($urandom_range(0, 3) == 0);
            cam_en = 1'($urandom);
            if (act <= 4) send(pool[$urandom_range(0, 7)], int'($urandom_range(0, 2)),
                               1'($urandom), pool[$urandom_range(0, 7)], 1'($urandom));
            else if (act <= 6) do_set(pool[$urandom_range(0, 7)], 1'($urandom));
            else if (act == 7 && $urandom_range(0, 7) == 0) do_clear();
            else if (act == 8) begin
                rx_byte_vld = 1'b1; rx_first = 1'($urandom); rx_byte = 8'($urandom); tick(); idle(1);
            end else idle(int'($urandom_range(1, 4)));
        end
        idle(10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule